// File: doc/BRIEF.md
# Uniform-Latency Register Writeback Stage

This block sits at the back end of a short in-order pipeline in which two kinds of instruction share one register-file write port. Arithmetic (ALU) instructions have no use for data memory and could retire one stage earlier than loads. Loads must pass through a memory access before their value exists. If an ALU instruction issues in the cycle right after a load, both would otherwise ask for the single write port in the same cycle.

The block removes that conflict by giving both kinds the same path: execute, memory, write. For an ALU instruction the memory stage is an empty pass-through that holds the sum for one cycle and never touches memory. Each instruction therefore uses each stage exactly once and in the same relative cycle. No two instructions can reach the write port together, so no stall or arbitration is needed. The execute stage forms `a + b`. For an ALU instruction this sum is the result. For a load it is the address, and the data comes back on `mem_rdata` in the same cycle. Writes that target register 0 are dropped.

Top module: `wb_align`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any clock edge that samples it low, `wr_en` and `mem_rd_en` are 0.
- R2: An ALU instruction (`issue_is_load`=0) sampled with `issue_valid`=1 at clock edge k produces `wr_en`=1, `wr_addr`=`issue_rd` and `wr_data`=`issue_a`+`issue_b` (modulo 2^DATA_W) in the cycle after edge k+2. It produces that write in that one cycle only.
- R3: A load (`issue_is_load`=1) sampled at edge k drives `mem_rd_en`=1 and `mem_addr`=`issue_a`+`issue_b` in the cycle after edge k+1. The value on `mem_rdata` in that cycle is written to `issue_rd` in the cycle after edge k+2.
- R4: Both instruction kinds reach the write port exactly three edges after issue, whatever mix of kinds is issued.
- R5: A load followed directly by an ALU instruction produces two writes in consecutive cycles, load first, each with its own address and data.
- R6: An instruction whose destination is register 0 produces no write. It does not disturb the writes of its neighbours.
- R7: At most one write request reaches the write port in any cycle.
- R8: An ALU instruction never asserts `mem_rd_en`.
- R9: A cycle with `issue_valid`=0 issues nothing, so three edges later it produces no write.
- R10: A synchronous reset discards every instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_is_load | input | 1 | 1 = load, 0 = ALU instruction |
| issue_rd | input | REG_AW | Destination register |
| issue_a | input | DATA_W | First operand (base for a load) |
| issue_b | input | DATA_W | Second operand (offset for a load) |
| mem_rd_en | output | 1 | Data-memory read strobe |
| mem_addr | output | DATA_W | Data-memory read address |
| mem_rdata | input | DATA_W | Data returned in the same cycle as the strobe |
| wr_en | output | 1 | Register-file write enable |
| wr_addr | output | REG_AW | Register-file write address |
| wr_data | output | DATA_W | Register-file write data |

## Verification
The hardest case to reach is the one the block exists for: a load in its memory stage while an ALU instruction sits one stage behind it. Only with that overlap would a shorter ALU path collide at the port. The stimulus issues a load and an ALU instruction on consecutive edges, in both orders. It feeds the load data exactly in the cycle the read strobe is observed, then checks that the two writes arrive on adjacent cycles with their own values. A continuous burst of back-to-back issues keeps every stage occupied at once. A reset dropped onto an instruction already in flight checks that nothing surfaces afterwards.

// File: rtl/wb_align_pkg.sv
// Package: shared encodings for the writeback aligner.
// Assumes: a single-bit kind field on the issue interface.
package wb_align_pkg;

    typedef enum logic {
        KIND_ALU  = 1'b0,
        KIND_LOAD = 1'b1
    } instr_kind_e;

endpackage

// File: rtl/wb_align_exec.sv
// Execute stage: captures the issued instruction and forms a + b, which is
// the result for an ALU instruction and the address for a load.
// Assumes: one instruction per cycle, no stall input.
module wb_align_exec #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  wb_align_pkg::instr_kind_e   in_kind,
    input  logic [REG_AW-1:0]           in_rd,
    input  logic [DATA_W-1:0]           in_a,
    input  logic [DATA_W-1:0]           in_b,
    output logic                        x_valid,
    output wb_align_pkg::instr_kind_e   x_kind,
    output logic [REG_AW-1:0]           x_rd,
    output logic [DATA_W-1:0]           x_sum
);
    logic [DATA_W-1:0] a_q, b_q;

    // Capture the issued instruction; bubbles clear the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_valid <= 1'b0;
            x_kind  <= wb_align_pkg::KIND_ALU;
            x_rd    <= '0;
            a_q     <= '0;
            b_q     <= '0;
        end else begin
            x_valid <= in_valid;
            x_kind  <= in_kind;
            x_rd    <= in_rd;
            a_q     <= in_a;
            b_q     <= in_b;
        end
    end

    // The single adder shared by both kinds.
    always_comb x_sum = a_q + b_q;

endmodule

// File: rtl/wb_align_mem.sv
// Memory stage: a load reads data memory here. An ALU instruction passes
// its sum through untouched, which is what aligns its writeback with loads.
// Assumes: memory returns read data combinationally in the strobe cycle.
module wb_align_mem #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        x_valid,
    input  wb_align_pkg::instr_kind_e   x_kind,
    input  logic [REG_AW-1:0]           x_rd,
    input  logic [DATA_W-1:0]           x_sum,
    output logic                        mem_rd_en,
    output logic [DATA_W-1:0]           mem_addr,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        ld_req,
    output logic                        alu_req,
    output logic [REG_AW-1:0]           m_rd,
    output logic [DATA_W-1:0]           m_data
);
    logic                      m_valid;
    wb_align_pkg::instr_kind_e m_kind;
    logic [DATA_W-1:0]         m_sum;
    logic                      rd_live;

    // Move the execute result into the memory stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_kind  <= wb_align_pkg::KIND_ALU;
            m_rd    <= '0;
            m_sum   <= '0;
        end else begin
            m_valid <= x_valid;
            m_kind  <= x_kind;
            m_rd    <= x_rd;
            m_sum   <= x_sum;
        end
    end

    // Strobe memory for loads only; select the value to write back.
    always_comb begin
        mem_rd_en = m_valid && (m_kind == wb_align_pkg::KIND_LOAD);
        mem_addr  = m_sum;
        rd_live   = (m_rd != '0);
        ld_req    = mem_rd_en && rd_live;
        alu_req   = m_valid && (m_kind == wb_align_pkg::KIND_ALU) && rd_live;
        m_data    = mem_rd_en ? mem_rdata : m_sum;
    end

endmodule

// File: rtl/wb_align_write.sv
// Write stage: registers the write requests from the memory stage and
// drives the one register-file write port.
// Assumes: requests for register 0 are already removed upstream.
module wb_align_write #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic              alu_req,
    input  logic [REG_AW-1:0] m_rd,
    input  logic [DATA_W-1:0] m_data,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic w_ld, w_alu;

    // Hold each source's request separately until the port takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_ld    <= 1'b0;
            w_alu   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            w_ld    <= ld_req;
            w_alu   <= alu_req;
            wr_addr <= m_rd;
            wr_data <= m_data;
        end
    end

    // Merge the two sources onto the single port.
    always_comb wr_en = w_ld || w_alu;

    // R7: the load path and the ALU path never request the port together.
    assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({w_ld, w_alu}) <= 1);

    // R6: register 0 is never written.
    assert_no_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != '0));

endmodule

// File: rtl/wb_align.sv
// Top: three-stage back end (execute, memory, write) that gives ALU
// instructions and loads the same writeback latency on one write port.
// Assumes: no stalls, no forwarding; loads see memory data in the strobe cycle.
module wb_align #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_is_load,
    input  logic [REG_AW-1:0] issue_rd,
    input  logic [DATA_W-1:0] issue_a,
    input  logic [DATA_W-1:0] issue_b,
    output logic              mem_rd_en,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    wb_align_pkg::instr_kind_e in_kind, x_kind;
    logic                      x_valid, ld_req, alu_req;
    logic [REG_AW-1:0]         x_rd, m_rd;
    logic [DATA_W-1:0]         x_sum, m_data;

    // Translate the issue kind bit into the shared encoding.
    always_comb in_kind = issue_is_load ? wb_align_pkg::KIND_LOAD
                                        : wb_align_pkg::KIND_ALU;

    wb_align_exec #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .in_valid(issue_valid), .in_kind(in_kind), .in_rd(issue_rd),
        .in_a(issue_a), .in_b(issue_b),
        .x_valid(x_valid), .x_kind(x_kind), .x_rd(x_rd), .x_sum(x_sum)
    );

    wb_align_mem #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .x_valid(x_valid), .x_kind(x_kind), .x_rd(x_rd), .x_sum(x_sum),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ld_req(ld_req), .alu_req(alu_req), .m_rd(m_rd), .m_data(m_data)
    );

    wb_align_write #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_write (
        .clk(clk), .rst_n(rst_n),
        .ld_req(ld_req), .alu_req(alu_req), .m_rd(m_rd), .m_data(m_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // R4: any live issue reaches the port exactly three edges later.
    assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_rd != '0) |-> ##3 (wr_en && wr_addr == $past(issue_rd, 3)));

    // R9: a write always traces back to a valid issue three edges earlier.
    assert_write_has_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(issue_valid, 3));

    // R8: the memory strobe only follows a load issued two edges earlier.
    assert_strobe_only_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(issue_valid && issue_is_load, 2));

endmodule

// File: tb/wb_align_bench.sv
module wb_align_bench;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          issue_valid, issue_is_load;
    logic [AW-1:0] issue_rd;
    logic [DW-1:0] issue_a, issue_b, mem_rdata;
    logic          mem_rd_en, wr_en;
    logic [DW-1:0] mem_addr, wr_data;
    logic [AW-1:0] wr_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wb_align #(.DATA_W(DW), .REG_AW(AW)) u_wb_align (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_is_load(issue_is_load),
        .issue_rd(issue_rd), .issue_a(issue_a), .issue_b(issue_b),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(bit ld, logic [AW-1:0] rd, logic [DW-1:0] a, logic [DW-1:0] b);
        issue_valid = 1'b1; issue_is_load = ld; issue_rd = rd; issue_a = a; issue_b = b;
    endtask

    task automatic idle();
        issue_valid = 1'b0; issue_is_load = 1'b0; issue_rd = '0; issue_a = '0; issue_b = '0;
    endtask

    task automatic expect_write(string tag, logic [AW-1:0] rd, logic [DW-1:0] d);
        check({tag, " wr_en"}, 64'(wr_en), 64'd1);
        check({tag, " wr_addr"}, 64'(wr_addr), 64'(rd));
        check({tag, " wr_data"}, 64'(wr_data), 64'(d));
    endtask

    // R2 / R8: a single ALU instruction, timing and pass-through.
    task automatic t_alu();
        @(negedge clk); drive(0, 5'd5, 32'd10, 32'd20);
        @(negedge clk); idle();
        check("R2 no early write", 64'(wr_en), 64'd0);
        @(negedge clk);
        check("R8 alu no strobe", 64'(mem_rd_en), 64'd0);
        check("R2 no early write", 64'(wr_en), 64'd0);
        @(negedge clk); expect_write("R2", 5'd5, 32'd30);
        @(negedge clk); check("R2 single write", 64'(wr_en), 64'd0);
        // sum wraps modulo 2^DW
        @(negedge clk); drive(0, 5'd31, 32'hFFFF_FFFF, 32'd2);
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk); expect_write("R2 wrap", 5'd31, 32'd1);
    endtask

    // R3 / R4: a single load, strobe timing and data capture.
    task automatic t_load();
        @(negedge clk); drive(1, 5'd7, 32'd100, 32'd4);
        @(negedge clk); idle();
        check("R3 no early strobe", 64'(mem_rd_en), 64'd0);
        @(negedge clk);
        check("R3 strobe", 64'(mem_rd_en), 64'd1);
        check("R3 addr", 64'(mem_addr), 64'd104);
        mem_rdata = 32'hDEAD_BEEF;
        @(negedge clk); mem_rdata = '0;
        expect_write("R4 load", 5'd7, 32'hDEAD_BEEF);
        check("R3 strobe drops", 64'(mem_rd_en), 64'd0);
    endtask

    // R5 / R7: load then ALU back to back, then ALU then load.
    task automatic t_pair();
        @(negedge clk); drive(1, 5'd3, 32'd8, 32'd8);
        @(negedge clk); drive(0, 5'd4, 32'd1, 32'd2);
        @(negedge clk); idle();
        check("R5 load strobe", 64'(mem_rd_en), 64'd1);
        check("R5 load addr", 64'(mem_addr), 64'd16);
        mem_rdata = 32'd55;
        @(negedge clk); mem_rdata = '0;
        expect_write("R5 first load", 5'd3, 32'd55);
        check("R8 alu behind load", 64'(mem_rd_en), 64'd0);
        @(negedge clk); expect_write("R5 second alu", 5'd4, 32'd3);
        @(negedge clk); drive(0, 5'd10, 32'd7, 32'd7);
        @(negedge clk); drive(1, 5'd11, 32'd40, 32'd2);
        @(negedge clk); idle();
        check("R8 alu first", 64'(mem_rd_en), 64'd0);
        @(negedge clk);
        expect_write("R5 alu first", 5'd10, 32'd14);
        check("R5 load strobe", 64'(mem_rd_en), 64'd1);
        check("R5 load addr", 64'(mem_addr), 64'd42);
        mem_rdata = 32'h1234;
        @(negedge clk); mem_rdata = '0;
        expect_write("R5 load second", 5'd11, 32'h1234);
    endtask

    // R6: register 0 destinations produce no write; neighbours unaffected.
    task automatic t_zero();
        @(negedge clk); drive(1, 5'd0, 32'd1, 32'd1);
        @(negedge clk); drive(0, 5'd9, 32'd2, 32'd3);
        @(negedge clk); drive(0, 5'd0, 32'd4, 32'd4);
        mem_rdata = 32'hAAAA;
        @(negedge clk); idle(); mem_rdata = '0;
        check("R6 load to r0", 64'(wr_en), 64'd0);
        @(negedge clk); expect_write("R6 neighbour", 5'd9, 32'd5);
        @(negedge clk); check("R6 alu to r0", 64'(wr_en), 64'd0);
    endtask

    // R4 / R7 / R9: continuous stream with a bubble in the middle.
    task automatic t_stream();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 3 && i - 3 < 7) begin
                if (i - 3 == 3) check("R9 bubble", 64'(wr_en), 64'd0);
                else if (((i - 3) % 2) == 1)
                    expect_write("R4 stream load", 5'(12 + i - 3), 32'(200 + i - 3));
                else
                    expect_write("R4 stream alu", 5'(12 + i - 3), 32'(2 * (i - 3)));
            end
            if (i < 7) begin
                if (i == 3) idle();
                else if ((i % 2) == 1) drive(1, 5'(12 + i), 32'd0, 32'd0);
                else drive(0, 5'(12 + i), 32'(i), 32'(i));
            end else idle();
            // load data for the instruction now in the memory stage (issued at i-2)
            mem_rdata = (i >= 2 && ((i - 2) % 2) == 1) ? 32'(200 + i - 2) : '0;
        end
        @(negedge clk); mem_rdata = '0;
        check("R9 idle after stream", 64'(wr_en), 64'd0);
    endtask

    // R10: reset drops an instruction already in flight.
    task automatic t_flush();
        @(negedge clk); drive(0, 5'd6, 32'd1, 32'd1);
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 after reset edge", 64'(wr_en), 64'd0);
        check("R10 flushed", 64'(wr_en), 64'd0);
        @(negedge clk); check("R10 flushed later", 64'(wr_en), 64'd0);
        @(negedge clk); check("R10 still quiet", 64'(wr_en), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; mem_rdata = '0; idle();
        repeat (3) @(negedge clk);
        check("R1 wr_en in reset", 64'(wr_en), 64'd0);
        check("R1 mem_rd_en in reset", 64'(mem_rd_en), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_alu();
        t_load();
        t_pair();
        t_zero();
        t_stream();
        t_flush();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule